// File: doc/BRIEF.md
# Trigger-Latency Pipeline Cell Controller

This block keeps the cell addresses of a circular analog storage pipeline in a strip-detector front end. Each acquisition tick (a one-cycle enable in the system clock domain) stores the current write cell in a history and moves the write pointer to the next free cell. The pointer moves up or down the ring, as a configuration bit selects. When a level-one accept comes with a tick, the block looks up the cell written a configured number of ticks earlier. It parks that cell in a small hold queue, and the write pointer steps around it until it is released. Acquisition never pauses while held cells wait for conversion.

The head of the hold queue goes to the digitizer as a cell number with a valid flag. A release pulse frees the head cell, which then rejoins the rotation. An accept that finds the queue full is dropped, and a sticky overflow flag records it. The queue occupancy is an enumerated machine with three states. ST_EMPTY goes to ST_PART on an accepted capture. ST_PART goes to ST_FULL when a capture fills the last slot, and back to ST_EMPTY when a release frees the only held cell. ST_FULL goes to ST_PART on a release. Cell 0 is the pedestal reference cell: it is never written and never reported.

Top module: `pipe_cell_ctrl`

## Requirements
- R1: After reset `wr_cell` is 1, `dig_valid` is 0 and `ovf_flag` is 0, whatever the configured order.
- R2: On each cycle with `acq_tick` high, `wr_cell` moves to the next cell of ring 1..46. With `cfg_order_dn`=0 it steps +1 and wraps 46→1. With `cfg_order_dn`=1 it steps −1 and wraps 1→46. Without a tick it holds.
- R3: An `l1a` in a tick cycle captures the cell that was `wr_cell` `cfg_latency` ticks earlier, where latency 0 means the current `wr_cell`. An `l1a` outside a tick cycle is ignored.
- R4: The write pointer never lands on a held cell. It skips every held cell, including several adjacent ones, as well as a cell captured in the same tick.
- R5: A captured cell appears on `dig_cell` with `dig_valid` high in the cycle after the capture edge. Held cells are presented in capture order, and a reported cell is never 0.
- R6: `dig_release` removes the head cell, so the next held cell (if any) appears one cycle later. A release while nothing is held has no effect.
- R7: An accept while 4 cells are held is dropped: the dropped cell is not held and is not skipped. `ovf_flag` goes high and stays high until reset.
- R8: An accept whose latency reaches back before the first tick after reset selects no written cell and is ignored without setting `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_tick | input | 1 | One-cycle acquisition clock tick |
| l1a | input | 1 | Level-one accept, honoured only with a tick |
| cfg_latency | input | 6 | Trigger latency in ticks |
| cfg_order_dn | input | 1 | Ring order: 0 ascending, 1 descending |
| dig_release | input | 1 | Digitization of the head cell finished |
| wr_cell | output | 6 | Cell being written this tick |
| dig_valid | output | 1 | A held cell awaits digitization |
| dig_cell | output | 6 | Held cell number for the digitizer |
| ovf_flag | output | 1 | Sticky: an accept was dropped on a full queue |

## Verification
The hardest condition to reach is the write pointer wrapping the ring into a run of adjacent held cells. It only happens after dozens of ticks while the queue stays full. The bench uses latency 0 and sends five back-to-back accepts, which hold cells 1 to 4 and overflow on the fifth. It then issues 41 plain ticks, so the pointer must jump from 46 over 1 to 4 and land on 5. A second run holds only cell 1 and wraps through it.

// File: rtl/plc_pkg.sv
package plc_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } occ_state_t;
endpackage

// File: rtl/plc_cell_history.sv
module plc_cell_history #(
    parameter int CELL_W = 6,
    parameter int LAT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CELL_W-1:0] cur_cell,
    input  logic [LAT_W-1:0]  latency,
    output logic [CELL_W-1:0] sel_cell
);
    localparam int DEPTH = 2 ** LAT_W;

    logic [CELL_W-1:0] hist_q [DEPTH];
    logic [LAT_W-1:0]  ptr_q;
    logic [LAT_W-1:0]  rd_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (tick) begin
            hist_q[ptr_q] <= cur_cell;
            ptr_q         <= ptr_q + LAT_W'(1);
        end
    end

    always_comb begin
        rd_idx   = ptr_q - latency;
        sel_cell = (latency == '0) ? cur_cell : hist_q[rd_idx];
    end

    // R3: the history slot just written holds the cell that was current
    assert_hist_record_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> hist_q[ptr_q - LAT_W'(1)] == $past(cur_cell));
endmodule

// File: rtl/plc_hold_fifo.sv
module plc_hold_fifo
    import plc_pkg::*;
#(
    parameter int CELL_W = 6,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [CELL_W-1:0] push_cell,
    input  logic              pop,
    output logic              head_valid,
    output logic [CELL_W-1:0] head_cell,
    output logic              full,
    output logic [CELL_W-1:0] slot_cell [SLOTS],
    output logic [SLOTS-1:0]  slot_live
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SLOTS);

    occ_state_t        state_q, state_d;
    logic [CELL_W-1:0] mem_q [SLOTS];
    logic [SLOTS-1:0]  live_q;
    logic [PTR_W-1:0]  rd_q, wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_push = push && (state_q != ST_FULL);
    assign do_pop  = pop  && (state_q != ST_EMPTY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
            rd_q   <= '0;
            wr_q   <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q]  <= push_cell;
                live_q[wr_q] <= 1'b1;
                wr_q         <= bump(wr_q);
            end
            if (do_pop) begin
                live_q[rd_q] <= 1'b0;
                rd_q         <= bump(rd_q);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (do_push) state_d = (SLOTS == 1) ? ST_FULL : ST_PART;
            end
            ST_PART: begin
                if (do_push && !do_pop && cnt_q == CNT_MAX - CNT_W'(1))
                    state_d = ST_FULL;
                else if (do_pop && !do_push && cnt_q == CNT_W'(1))
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (do_pop) state_d = (SLOTS == 1) ? ST_EMPTY : ST_PART;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        head_valid = (state_q != ST_EMPTY);
        full       = (state_q == ST_FULL);
        head_cell  = mem_q[rd_q];
        slot_live  = live_q;
        for (int i = 0; i < SLOTS; i++) slot_cell[i] = mem_q[i];
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
    assert_state_matches_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) == (state_q == ST_EMPTY));
    assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && !do_push) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
    assert_head_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid |-> live_q[rd_q]);
    assert_live_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(live_q) == int'(cnt_q));
endmodule

// File: rtl/plc_write_ptr.sv
module plc_write_ptr #(
    parameter int RING   = 46,
    parameter int CELL_W = 6,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              order_dn,
    input  logic [CELL_W-1:0] held_cell [SLOTS],
    input  logic [SLOTS-1:0]  held_live,
    input  logic              cap_valid,
    input  logic [CELL_W-1:0] cap_cell,
    output logic [CELL_W-1:0] wr_cell
);
    localparam int NCAND = SLOTS + 2;
    localparam logic [CELL_W-1:0] TOP_CELL = CELL_W'(RING);
    localparam logic [CELL_W-1:0] ONE_CELL = CELL_W'(1);

    logic [CELL_W-1:0] wr_q, nxt;

    function automatic logic [CELL_W-1:0] step_cell(input logic [CELL_W-1:0] c,
                                                    input logic dn);
        if (dn) return (c <= ONE_CELL) ? TOP_CELL : c - ONE_CELL;
        else    return (c >= TOP_CELL) ? ONE_CELL : c + ONE_CELL;
    endfunction

    always_comb begin
        logic [CELL_W-1:0] cand;
        logic              found;
        logic              hit;
        cand  = step_cell(wr_q, order_dn);
        nxt   = cand;
        found = 1'b0;
        for (int k = 0; k < NCAND; k++) begin
            hit = cap_valid && (cap_cell == cand);
            for (int j = 0; j < SLOTS; j++)
                hit = hit | (held_live[j] && (held_cell[j] == cand));
            if (!found && !hit) begin
                nxt   = cand;
                found = 1'b1;
            end
            cand = step_cell(cand, order_dn);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    wr_q <= ONE_CELL;
        else if (tick) wr_q <= nxt;
    end

    assign wr_cell = wr_q;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(wr_q));
    assert_in_ring_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q >= ONE_CELL) && (wr_q <= TOP_CELL));

    for (genvar g = 0; g < SLOTS; g++) begin : g_skip_chk
        assert_wr_not_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
            held_live[g] |-> held_cell[g] != wr_q);
    end
endmodule

// File: rtl/pipe_cell_ctrl.sv
module pipe_cell_ctrl #(
    parameter int RING_CELLS = 46,
    parameter int HOLD_SLOTS = 4,
    parameter int LAT_W      = 6,
    parameter int CELL_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_tick,
    input  logic              l1a,
    input  logic [LAT_W-1:0]  cfg_latency,
    input  logic              cfg_order_dn,
    input  logic              dig_release,
    output logic [CELL_W-1:0] wr_cell,
    output logic              dig_valid,
    output logic [CELL_W-1:0] dig_cell,
    output logic              ovf_flag
);
    logic [CELL_W-1:0] cur_cell, sel_cell, head_cell;
    logic [CELL_W-1:0] slot_cell [HOLD_SLOTS];
    logic [HOLD_SLOTS-1:0] slot_live;
    logic head_valid, q_full, cap_req, accept, drop, ovf_q;

    assign cap_req = acq_tick && l1a && (sel_cell != '0);
    assign accept  = cap_req && !q_full;
    assign drop    = cap_req && q_full;

    plc_cell_history #(.CELL_W(CELL_W), .LAT_W(LAT_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .tick(acq_tick), .cur_cell(cur_cell),
        .latency(cfg_latency), .sel_cell(sel_cell)
    );

    plc_hold_fifo #(.CELL_W(CELL_W), .SLOTS(HOLD_SLOTS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(accept), .push_cell(sel_cell),
        .pop(dig_release), .head_valid(head_valid), .head_cell(head_cell),
        .full(q_full), .slot_cell(slot_cell), .slot_live(slot_live)
    );

    plc_write_ptr #(.RING(RING_CELLS), .CELL_W(CELL_W), .SLOTS(HOLD_SLOTS)) u_wptr (
        .clk(clk), .rst_n(rst_n), .tick(acq_tick), .order_dn(cfg_order_dn),
        .held_cell(slot_cell), .held_live(slot_live), .cap_valid(accept),
        .cap_cell(sel_cell), .wr_cell(cur_cell)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_q <= 1'b0;
        else if (drop) ovf_q <= 1'b1;
    end

    assign wr_cell   = cur_cell;
    assign dig_valid = head_valid;
    assign dig_cell  = head_cell;
    assign ovf_flag  = ovf_q;

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
    assert_cell_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid |-> dig_cell != '0);
    assert_capture_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> dig_valid);
    assert_no_tick_no_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq_tick && !dig_release) |=> $stable(dig_valid) && $stable(dig_cell));
endmodule

// File: tb/pipe_cell_ctrl_tb.sv
module pipe_cell_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acq_tick = 1'b0, l1a = 1'b0, dig_release = 1'b0, cfg_order_dn = 1'b0;
    logic [5:0] cfg_latency = 6'd0;
    logic [5:0] wr_cell, dig_cell;
    logic       dig_valid, ovf_flag;
    int         n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    pipe_cell_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .acq_tick(acq_tick), .l1a(l1a),
        .cfg_latency(cfg_latency), .cfg_order_dn(cfg_order_dn),
        .dig_release(dig_release), .wr_cell(wr_cell), .dig_valid(dig_valid),
        .dig_cell(dig_cell), .ovf_flag(ovf_flag)
    );

    // {tick, l1a, release, exp wr_cell, exp dig_valid, exp dig_cell}; latency 2, ascending
    localparam logic [15:0] VEC [9] = '{
        {3'b100, 6'd2, 1'b0, 6'd0},
        {3'b100, 6'd3, 1'b0, 6'd0},
        {3'b110, 6'd4, 1'b1, 6'd1},
        {3'b100, 6'd5, 1'b1, 6'd1},
        {3'b110, 6'd6, 1'b1, 6'd1},
        {3'b001, 6'd6, 1'b1, 6'd3},
        {3'b001, 6'd6, 1'b0, 6'd0},
        {3'b001, 6'd6, 1'b0, 6'd0},
        {3'b010, 6'd6, 1'b0, 6'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic a, input logic r);
        acq_tick = t; l1a = a; dig_release = r;
        @(posedge clk);
        #1;
        acq_tick = 1'b0; l1a = 1'b0; dig_release = 1'b0;
    endtask

    task automatic do_reset(input logic dn, input logic [5:0] lat);
        rst_n = 1'b0; cfg_order_dn = dn; cfg_latency = lat;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1 wr_cell", int'(wr_cell), 1);
        chk("R1 dig_valid", int'(dig_valid), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // Table walk: R2 R3 R5 R6
        do_reset(1'b0, 6'd2);
        for (int i = 0; i < 9; i++) begin
            step(VEC[i][15], VEC[i][14], VEC[i][13]);
            chk("R2 table wr_cell", int'(wr_cell), int'(VEC[i][12:7]));
            chk("R5 table dig_valid", int'(dig_valid), int'(VEC[i][6]));
            if (VEC[i][6]) chk("R3 table dig_cell", int'(dig_cell), int'(VEC[i][5:0]));
        end

        // R2 descending order and wrap 1->46
        do_reset(1'b1, 6'd0);
        step(1, 0, 0);
        chk("R2 down wrap", int'(wr_cell), 46);
        step(1, 0, 0);
        chk("R2 down step", int'(wr_cell), 45);
        step(0, 0, 0);
        chk("R2 no tick hold", int'(wr_cell), 45);

        // R4 single held cell skipped on wrap
        do_reset(1'b0, 6'd0);
        step(1, 1, 0);
        chk("R3 latency0 capture", int'(dig_cell), 1);
        chk("R4 skip captured", int'(wr_cell), 2);
        for (int i = 0; i < 44; i++) step(1, 0, 0);
        chk("R2 up reaches 46", int'(wr_cell), 46);
        step(1, 0, 0);
        chk("R4 wrap skips held 1", int'(wr_cell), 2);

        // R7 overflow and R4 skipping adjacent held cells
        do_reset(1'b0, 6'd0);
        for (int i = 0; i < 5; i++) step(1, 1, 0);
        chk("R7 ovf set", int'(ovf_flag), 1);
        chk("R7 dropped not skipped", int'(wr_cell), 6);
        chk("R5 fifo head", int'(dig_cell), 1);
        for (int i = 0; i < 41; i++) step(1, 0, 0);
        chk("R4 skip run 1..4", int'(wr_cell), 5);
        step(0, 0, 1);
        chk("R6 next head 2", int'(dig_cell), 2);
        step(0, 0, 1);
        chk("R6 next head 3", int'(dig_cell), 3);
        step(0, 0, 1);
        chk("R6 next head 4", int'(dig_cell), 4);
        step(0, 0, 1);
        chk("R6 empty after pops", int'(dig_valid), 0);
        step(0, 0, 1);
        chk("R6 release on empty", int'(dig_valid), 0);
        chk("R7 ovf sticky", int'(ovf_flag), 1);

        // R8 accept before history is filled
        do_reset(1'b0, 6'd3);
        step(1, 1, 0);
        chk("R8 early accept ignored", int'(dig_valid), 0);
        chk("R8 no overflow", int'(ovf_flag), 0);
        step(1, 0, 0);
        step(1, 0, 0);
        step(1, 1, 0);
        chk("R3 latency3 valid", int'(dig_valid), 1);
        chk("R3 latency3 cell", int'(dig_cell), 1);
        chk("R4 after latency capture", int'(wr_cell), 5);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule